// File: doc/BRIEF.md
# Shared Physical Register Reference Counter

This block counts how many references (rename-map entries plus in-flight reorder entries) point at each physical register. A renamer that removes register-to-register moves lets two architectural names share one physical register, so a register may only be recycled once its last reference is gone. Each cycle the block accepts up to four speculative events. Each event either adds a reference to a physical register or drops one from it. Several events in one cycle may name the same register. The block folds them into one net change per register and keeps a free mask in step with the counters.

A second bank of counters follows retirement-side events and holds the committed view. When the pipeline is flushed, the speculative counters are overwritten with that committed view and the free mask is rebuilt from it. The lowest-numbered free register is offered to the renamer on a valid-only output. The offer has no ready signal and no back-pressure: the renamer claims the offered register by issuing an allocate event that names it. Until that event lands, the offer keeps pointing at the same register. A combinational query port reads both counters of one register.

Top module: `preg_refcount`

## Requirements
- R1: After reset, physical registers 0 to ARCH_REGS-1 hold a count of 1 in both banks and all higher registers hold 0; the free mask has exactly the bits of the zero-count registers set.
- R2: Event slot n is active when bit n of its valid vector is 1. Bit n of the kind vector selects allocate (1, +1) or release (0, -1). The register id sits in bits [n*PREG_W +: PREG_W].
- R3: On the clock edge after a set of speculative events, each named register's count equals its previous count plus the sum of the +1/-1 deltas of all active slots that name it, whichever slots those are. A same-cycle allocate and release of one register leaves its count unchanged. Registers that no slot names keep their count.
- R4: A register's free-mask bit clears on the edge where its count leaves zero and sets on the edge where its count reaches zero.
- R5: `free_valid` is high exactly when the free mask is non-zero, and `free_preg` is then the lowest-indexed free register.
- R6: Committed counters change only by commit-slot events, with the same encoding and net-sum rule as R2 and R3, and ignore speculative events and flushes.
- R7: On the edge that samples `flush` high, every speculative counter takes the committed value including that cycle's commit events; speculative events in that cycle have no effect; the free mask becomes the set of registers whose restored count is zero.
- R8: `qry_spec_cnt` and `qry_cmt_cnt` show the current registered counts of register `qry_preg`, with no clock delay.
- R9: Under legal use no counter is ever decremented below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sp_vld | input | SLOTS | Speculative slot active bits |
| sp_alloc | input | SLOTS | Speculative slot kind, 1 = allocate, 0 = release |
| sp_preg | input | SLOTS*PREG_W | Speculative slot register ids |
| cm_vld | input | SLOTS | Commit slot active bits |
| cm_alloc | input | SLOTS | Commit slot kind, 1 = allocate, 0 = release |
| cm_preg | input | SLOTS*PREG_W | Commit slot register ids |
| flush | input | 1 | Restore speculative state from committed state |
| free_valid | output | 1 | A free register is offered |
| free_preg | output | PREG_W | Lowest-indexed free register |
| free_mask | output | NUM_PREGS | One bit per register, 1 = free |
| qry_preg | input | PREG_W | Register to inspect |
| qry_spec_cnt | output | CNT_W | Speculative count of `qry_preg` |
| qry_cmt_cnt | output | CNT_W | Committed count of `qry_preg` |

## Verification
The two functions that can land in one cycle are the commit-side update and the flush restore. When they do, the restored speculative counts must already include that cycle's commit events, and the speculative events presented alongside must vanish. The bench provokes this with directed cycles that mix commit releases, speculative allocates and a flush on the same edge, and with random flushes spread across thousands of cycles of legal traffic. Each cycle the bench compares every register's two counts, the free mask and the offered register against a behavioural model that sums deltas with plain integers.

// File: rtl/prc_pkg.sv
package prc_pkg;
  // Event kind carried on each slot's kind bit
  typedef enum logic {
    EV_RELEASE = 1'b0,
    EV_ALLOC   = 1'b1
  } ev_kind_e;
endpackage

// File: rtl/prc_net_adder.sv
// Net reference change, over all active slots, for the register named by one key
module prc_net_adder #(
  parameter int SLOTS  = 4,
  parameter int PREG_W = 4,
  parameter int NET_W  = 8
) (
  input  logic [SLOTS-1:0]        vld,
  input  logic [SLOTS-1:0]        kind,
  input  logic [SLOTS*PREG_W-1:0] preg,
  input  logic [PREG_W-1:0]       key,
  output logic signed [NET_W-1:0] net
);
  import prc_pkg::*;

  localparam logic signed [NET_W-1:0] PLUS1  = NET_W'(1);
  localparam logic signed [NET_W-1:0] MINUS1 = -NET_W'(1);

  always_comb begin
    net = '0;
    for (int m = 0; m < SLOTS; m++) begin
      if (vld[m] && (preg[m*PREG_W +: PREG_W] == key)) begin
        if (ev_kind_e'(kind[m]) == EV_ALLOC) net = net + PLUS1;
        else                                 net = net + MINUS1;
      end
    end
  end
endmodule

// File: rtl/prc_count_bank.sv
// Array of reference counters, updated by up to SLOTS events per cycle
module prc_count_bank #(
  parameter int NUM_PREGS = 16,
  parameter int ARCH_REGS = 8,
  parameter int SLOTS     = 4,
  parameter int PREG_W    = 4,
  parameter int CNT_W     = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [SLOTS-1:0]                  vld,
  input  logic [SLOTS-1:0]                  kind,
  input  logic [SLOTS*PREG_W-1:0]           preg,
  input  logic                              restore,
  input  logic [NUM_PREGS-1:0][CNT_W-1:0]   restore_cnt,
  output logic [NUM_PREGS-1:0][CNT_W-1:0]   cnt_q,
  output logic [NUM_PREGS-1:0][CNT_W-1:0]   cnt_d,
  output logic [SLOTS-1:0]                  udf
);
  localparam int NET_W = CNT_W + 2;

  logic signed [NET_W-1:0] net [SLOTS];
  logic signed [NET_W-1:0] sum [SLOTS];
  logic [PREG_W-1:0]       key [SLOTS];

  // One adder per slot; each computes the net change for its own register
  for (genvar n = 0; n < SLOTS; n++) begin : g_adder
    assign key[n] = preg[n*PREG_W +: PREG_W];

    prc_net_adder #(
      .SLOTS (SLOTS),
      .PREG_W(PREG_W),
      .NET_W (NET_W)
    ) u_add (
      .vld (vld),
      .kind(kind),
      .preg(preg),
      .key (key[n]),
      .net (net[n])
    );

    assign sum[n] = $signed({2'b00, cnt_q[key[n]]}) + net[n];
    assign udf[n] = vld[n] && sum[n][NET_W-1];
  end

  // Fixed priority: the lowest active slot naming a register writes it
  always_comb begin
    if (restore) begin
      cnt_d = restore_cnt;
    end else begin
      cnt_d = cnt_q;
      for (int r = 0; r < NUM_PREGS; r++) begin
        for (int n = SLOTS - 1; n >= 0; n--) begin
          if (vld[n] && (key[n] == PREG_W'(r))) cnt_d[r] = sum[n][CNT_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_PREGS; r++)
        cnt_q[r] <= (r < ARCH_REGS) ? CNT_W'(1) : '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/prc_free_pick.sv
// Lowest-index selection from the free mask
module prc_free_pick #(
  parameter int NUM_PREGS = 16,
  parameter int PREG_W    = 4
) (
  input  logic [NUM_PREGS-1:0] mask,
  output logic                 valid,
  output logic [PREG_W-1:0]    idx
);
  always_comb begin
    idx = '0;
    for (int i = NUM_PREGS - 1; i >= 0; i--) begin
      if (mask[i]) idx = PREG_W'(i);
    end
  end
  assign valid = |mask;
endmodule

// File: rtl/preg_refcount.sv
// Speculative and committed reference counters with an in-step free mask
module preg_refcount #(
  parameter int NUM_PREGS = 16,
  parameter int ARCH_REGS = 8,
  parameter int ROB_DEPTH = 32,
  parameter int SLOTS     = 4,
  localparam int PREG_W   = (NUM_PREGS > 1) ? $clog2(NUM_PREGS) : 1,
  localparam int CNT_W    = $clog2(ROB_DEPTH + ARCH_REGS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SLOTS-1:0]         sp_vld,
  input  logic [SLOTS-1:0]         sp_alloc,
  input  logic [SLOTS*PREG_W-1:0]  sp_preg,
  input  logic [SLOTS-1:0]         cm_vld,
  input  logic [SLOTS-1:0]         cm_alloc,
  input  logic [SLOTS*PREG_W-1:0]  cm_preg,
  input  logic                     flush,
  output logic                     free_valid,
  output logic [PREG_W-1:0]        free_preg,
  output logic [NUM_PREGS-1:0]     free_mask,
  input  logic [PREG_W-1:0]        qry_preg,
  output logic [CNT_W-1:0]         qry_spec_cnt,
  output logic [CNT_W-1:0]         qry_cmt_cnt
);
  logic [NUM_PREGS-1:0][CNT_W-1:0] spec_q, spec_d;
  logic [NUM_PREGS-1:0][CNT_W-1:0] cmt_q, cmt_d;
  logic [SLOTS-1:0]                sp_udf, cm_udf;
  logic [NUM_PREGS-1:0]            free_q, free_d;

  // Committed bank: retirement events only, never restored
  prc_count_bank #(
    .NUM_PREGS(NUM_PREGS), .ARCH_REGS(ARCH_REGS), .SLOTS(SLOTS),
    .PREG_W(PREG_W), .CNT_W(CNT_W)
  ) u_cmt (
    .clk        (clk),
    .rst_n      (rst_n),
    .vld        (cm_vld),
    .kind       (cm_alloc),
    .preg       (cm_preg),
    .restore    (1'b0),
    .restore_cnt('0),
    .cnt_q      (cmt_q),
    .cnt_d      (cmt_d),
    .udf        (cm_udf)
  );

  // Speculative bank: overwritten by the updated committed values on flush
  prc_count_bank #(
    .NUM_PREGS(NUM_PREGS), .ARCH_REGS(ARCH_REGS), .SLOTS(SLOTS),
    .PREG_W(PREG_W), .CNT_W(CNT_W)
  ) u_spec (
    .clk        (clk),
    .rst_n      (rst_n),
    .vld        (sp_vld),
    .kind       (sp_alloc),
    .preg       (sp_preg),
    .restore    (flush),
    .restore_cnt(cmt_d),
    .cnt_q      (spec_q),
    .cnt_d      (spec_d),
    .udf        (sp_udf)
  );

  // Free mask follows zero crossings; rebuilt wholesale on flush
  always_comb begin
    for (int r = 0; r < NUM_PREGS; r++) begin
      if (flush) begin
        free_d[r] = (spec_d[r] == '0);
      end else begin
        free_d[r] = free_q[r];
        if ((spec_q[r] == '0) && (spec_d[r] != '0)) free_d[r] = 1'b0;
        if ((spec_q[r] != '0) && (spec_d[r] == '0)) free_d[r] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_PREGS; r++) free_q[r] <= (r >= ARCH_REGS);
    end else begin
      free_q <= free_d;
    end
  end

  prc_free_pick #(
    .NUM_PREGS(NUM_PREGS), .PREG_W(PREG_W)
  ) u_pick (
    .mask (free_q),
    .valid(free_valid),
    .idx  (free_preg)
  );

  assign free_mask = free_q;

  always_comb begin
    qry_spec_cnt = '0;
    qry_cmt_cnt  = '0;
    if (int'(qry_preg) < NUM_PREGS) begin
      qry_spec_cnt = spec_q[qry_preg];
      qry_cmt_cnt  = cmt_q[qry_preg];
    end
  end
endmodule

// File: rtl/prc_refcount_chk.sv
module prc_refcount_chk #(
  parameter int NUM_PREGS = 16,
  parameter int SLOTS     = 4,
  parameter int PREG_W    = 4,
  parameter int CNT_W     = 6
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            flush,
  input logic [SLOTS-1:0]                sp_vld,
  input logic                            free_valid,
  input logic [PREG_W-1:0]               free_preg,
  input logic [NUM_PREGS-1:0]            free_mask,
  input logic [NUM_PREGS-1:0][CNT_W-1:0] spec_cnt,
  input logic [NUM_PREGS-1:0][CNT_W-1:0] cmt_cnt,
  input logic [SLOTS-1:0]                sp_udf,
  input logic [SLOTS-1:0]                cm_udf
);
  logic [NUM_PREGS-1:0] zero_v;
  logic [NUM_PREGS-1:0] below_v;

  always_comb begin
    for (int r = 0; r < NUM_PREGS; r++) begin
      zero_v[r]  = (spec_cnt[r] == '0);
      below_v[r] = (r < int'(free_preg));
    end
  end

  AST_FREE_TRACKS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    free_mask == zero_v); // R4

  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |-> (free_mask[free_preg] && ((free_mask & below_v) == '0))); // R5

  AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !free_valid |-> (free_mask == '0)); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((sp_vld == '0) && !flush) |=> $stable(spec_cnt)); // R3

  AST_FLUSH_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (spec_cnt == cmt_cnt)); // R7

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(|sp_udf) && !(|cm_udf)); // R9
endmodule

bind preg_refcount prc_refcount_chk #(
  .NUM_PREGS(NUM_PREGS), .SLOTS(SLOTS), .PREG_W(PREG_W), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .sp_vld    (sp_vld),
  .free_valid(free_valid),
  .free_preg (free_preg),
  .free_mask (free_mask),
  .spec_cnt  (spec_q),
  .cmt_cnt   (cmt_q),
  .sp_udf    (sp_udf),
  .cm_udf    (cm_udf)
);

// File: tb/preg_refcount_tb.sv
`timescale 1ns/10ps
module preg_refcount_tb;
  localparam int NP   = 16;
  localparam int AR   = 8;
  localparam int ROB  = 32;
  localparam int S    = 4;
  localparam int PW   = 4;
  localparam int CW   = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [S-1:0]  sp_vld, sp_alloc, cm_vld, cm_alloc;
  logic [S*PW-1:0] sp_preg, cm_preg;
  logic          flush;
  logic          free_valid;
  logic [PW-1:0] free_preg;
  logic [NP-1:0] free_mask;
  logic [PW-1:0] qry_preg;
  logic [CW-1:0] qry_spec_cnt, qry_cmt_cnt;

  always #2 clk = ~clk;

  preg_refcount #(.NUM_PREGS(NP), .ARCH_REGS(AR), .ROB_DEPTH(ROB), .SLOTS(S)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .sp_vld(sp_vld), .sp_alloc(sp_alloc), .sp_preg(sp_preg),
    .cm_vld(cm_vld), .cm_alloc(cm_alloc), .cm_preg(cm_preg),
    .flush(flush),
    .free_valid(free_valid), .free_preg(free_preg), .free_mask(free_mask),
    .qry_preg(qry_preg), .qry_spec_cnt(qry_spec_cnt), .qry_cmt_cnt(qry_cmt_cnt)
  );

  int m_spec [NP];
  int m_cmt  [NP];
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  task automatic clear_ev();
    sp_vld = '0; sp_alloc = '0; sp_preg = '0;
    cm_vld = '0; cm_alloc = '0; cm_preg = '0;
    flush = 1'b0;
  endtask

  task automatic set_sp(int n, bit alloc, int r);
    sp_vld[n] = 1'b1; sp_alloc[n] = alloc; sp_preg[n*PW +: PW] = PW'(r);
  endtask

  task automatic set_cm(int n, bit alloc, int r);
    cm_vld[n] = 1'b1; cm_alloc[n] = alloc; cm_preg[n*PW +: PW] = PW'(r);
  endtask

  // Model: plain integer sums per register
  task automatic model_update();
    int ds [NP];
    int dc [NP];
    for (int r = 0; r < NP; r++) begin ds[r] = 0; dc[r] = 0; end
    for (int n = 0; n < S; n++) begin
      if (sp_vld[n]) ds[int'(sp_preg[n*PW +: PW])] += sp_alloc[n] ? 1 : -1;
      if (cm_vld[n]) dc[int'(cm_preg[n*PW +: PW])] += cm_alloc[n] ? 1 : -1;
    end
    for (int r = 0; r < NP; r++) begin
      m_cmt[r] += dc[r];
      if (flush) m_spec[r] = m_cmt[r];
      else       m_spec[r] += ds[r];
    end
  endtask

  task automatic check_state(string tag);
    bit bad = 0;
    logic [NP-1:0] exp_mask;
    int exp_pick = 0;
    for (int r = NP - 1; r >= 0; r--) begin
      exp_mask[r] = (m_spec[r] == 0);
      if (m_spec[r] == 0) exp_pick = r;
    end
    compared++;
    if (free_mask !== exp_mask) begin
      bad = 1;
      $display("FAIL %s free_mask actual=%h expected=%h", tag, free_mask, exp_mask);
    end
    if (free_valid !== (exp_mask != '0)) begin
      bad = 1;
      $display("FAIL R5 free_valid actual=%b expected=%b", free_valid, (exp_mask != '0));
    end else if (free_valid && (int'(free_preg) != exp_pick)) begin
      bad = 1;
      $display("FAIL R5 free_preg actual=%0d expected=%0d", free_preg, exp_pick);
    end
    for (int r = 0; r < NP; r++) begin
      qry_preg = PW'(r);
      #0.1;
      if (int'(qry_spec_cnt) != m_spec[r]) begin
        bad = 1;
        $display("FAIL %s spec[%0d] actual=%0d expected=%0d", tag, r, qry_spec_cnt, m_spec[r]);
      end
      if (int'(qry_cmt_cnt) != m_cmt[r]) begin
        bad = 1;
        $display("FAIL %s cmt[%0d] actual=%0d expected=%0d", tag, r, qry_cmt_cnt, m_cmt[r]);
      end
    end
    if (bad) mismatched++;
  endtask

  // Inputs are already driven mid-cycle; advance one edge and compare
  task automatic step(string tag);
    model_update();
    @(posedge clk);
    #1;
    clear_ev();
    check_state(tag);
  endtask

  // Legal random traffic: never below zero, never near the counter ceiling
  task automatic rand_cycle();
    int ps [NP];
    int pc [NP];
    for (int r = 0; r < NP; r++) begin ps[r] = m_spec[r]; pc[r] = m_cmt[r]; end
    for (int n = 0; n < S; n++) begin
      if ($urandom_range(3) != 0) begin
        int r = $urandom_range(NP - 1);
        bit a = $urandom_range(1) == 1;
        if (!a && ps[r] <= 0) a = 1;
        if (a && ps[r] >= 50) a = 0;
        ps[r] += a ? 1 : -1;
        set_sp(n, a, r);
      end
      if ($urandom_range(2) == 0) begin
        int r = $urandom_range(NP - 1);
        bit a = $urandom_range(1) == 1;
        if (!a && pc[r] <= 0) a = 1;
        if (a && pc[r] >= 50) a = 0;
        pc[r] += a ? 1 : -1;
        set_cm(n, a, r);
      end
    end
    flush = ($urandom_range(39) == 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0;
    qry_preg = '0;
    clear_ev();
    for (int r = 0; r < NP; r++) begin
      m_spec[r] = (r < AR) ? 1 : 0;
      m_cmt[r]  = m_spec[r];
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_state("R1");

    // R3: allocate and release of one register cancel; idle registers hold
    set_sp(0, 1'b1, 3); set_sp(2, 1'b0, 3);
    step("R3");
    // R3 and R2: four allocates of a free register from all slots
    for (int n = 0; n < S; n++) set_sp(n, 1'b1, 8);
    step("R3");
    // R3: higher slots name it too, net -3 while slot 0 names another register
    set_sp(0, 1'b1, 2); set_sp(1, 1'b0, 8); set_sp(2, 1'b0, 8); set_sp(3, 1'b0, 8);
    step("R3");
    // R4: last release returns register 8 to the free mask
    set_sp(3, 1'b0, 8);
    step("R4");
    // R5: drain the free mask to empty over two cycles
    for (int n = 0; n < S; n++) set_sp(n, 1'b1, 8 + n);
    step("R5");
    for (int n = 0; n < S; n++) set_sp(n, 1'b1, 12 + n);
    step("R5");
    // R5: one register freed mid-range becomes the offer
    set_sp(1, 1'b0, 13);
    step("R5");
    // R6: commit events alone; speculative side untouched
    set_cm(0, 1'b1, 9); set_cm(3, 1'b1, 9); set_cm(1, 1'b0, 0);
    step("R6");
    // R7: flush with same-cycle commit and speculative events
    set_cm(2, 1'b0, 9); set_cm(0, 1'b1, 14);
    set_sp(0, 1'b1, 4); set_sp(1, 1'b0, 10);
    flush = 1'b1;
    step("R7");
    // R8: query port follows after a quiet cycle
    step("R8");

    for (int i = 0; i < 3000; i++) begin
      rand_cycle();
      step(flush ? "R7" : "R3");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule